// File: doc/BRIEF.md
# Indirect Segmented Queue RAM Port

This block holds the working storage of a serial queue engine: a 48-location RAM made of three 16-entry segments. One segment holds outgoing 16-bit words. Another holds incoming 16-bit words. The third holds 8-bit command bytes. The processor cannot address this storage directly. It first loads a 6-bit pointer register and then moves data through a single data register. Each data access, whether it is kept or discarded, advances the pointer by one. The segment decides the direction the processor may use: it may write outgoing words and commands, and it may only read incoming words. A data read has one wait state more than a write.

The serial sequencer has a second, direct port. On it the sequencer reads commands and outgoing words and stores incoming words. Both ports share one RAM access per cycle, and the sequencer wins any collision. The losing processor data access waits for the next free cycle.

Top module: `qram_port`

## Requirements
- R1: Address map: 0x00–0x0F are outgoing words (16 bit), 0x10–0x1F are incoming words (16 bit) and 0x20–0x2F are command bytes (8 bit, read back zero-extended). Addresses 0x30–0x3F are unmapped: writes there are dropped and reads return 0.
- R2: With cpu_sel=0 the processor reaches the pointer register. A write loads cpu_wdata[5:0]. A read returns the pointer zero-extended. cpu_ack rises in the cycle after the request edge. cpu_req is held until cpu_ack.
- R3: With cpu_sel=1 a processor write stores cpu_wdata at the pointer when the pointer is in the outgoing or command segment. cpu_ack follows one cycle after the request edge.
- R4: A processor data write to the incoming segment or to the unmapped range leaves the storage unchanged.
- R5: Every processor data access adds 1 to the pointer, discarded ones included, and the pointer wraps from 0x3F to 0x00.
- R6: A processor data read returns the incoming word at the pointer. cpu_ack rises two cycles after the request edge, which is one wait state more than a write.
- R7: A processor data read of the outgoing segment, the command segment or the unmapped range returns 0.
- R8: A sequencer read (seq_we=0) returns the outgoing word or command byte at seq_addr on seq_rdata in the cycle after the request. A sequencer read of the incoming segment or the unmapped range returns 0.
- R9: A sequencer write stores seq_wdata into the incoming segment. A sequencer write elsewhere is dropped.
- R10: When seq_req coincides with a pending processor data access, the sequencer is served first and the processor access finishes one cycle later for each such cycle. Pointer register accesses are never delayed.
- R11: After reset the pointer is 0, cpu_ack is low and both read data outputs are 0. RAM contents are not initialised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor request, held until cpu_ack |
| cpu_sel | input | 1 | 0 = pointer register, 1 = data register |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 16 | Processor write data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 16 | Processor read data, valid with cpu_ack |
| seq_req | input | 1 | Sequencer access in this cycle |
| seq_we | input | 1 | Sequencer write (incoming segment only) |
| seq_addr | input | 6 | Sequencer RAM address |
| seq_wdata | input | 16 | Sequencer write data |
| seq_rdata | output | 16 | Sequencer read data, valid the cycle after the request |

## Verification
Outgoing words are written in a run with distinct values and read back by the sequencer. This shows that the pointer increments and does not just store to a fixed slot. Command writes use values with nonzero upper bytes, which exposes any wrong width or missing zero-extension. Forbidden-direction accesses are checked in two ways: a discarded write is followed by a legal read of the same location, and each discard is followed by a pointer read, so direction gating and the increment are judged separately. Collisions are driven with processor writes, processor reads and pointer accesses, and each is timed by its latency in cycles. This separates a correct one-cycle stall from a lost access, a missing wait state and a delay applied to register accesses by mistake.

// File: rtl/qram_pkg.sv
package qram_pkg;

   typedef enum logic [1:0] {
      SEG_TX   = 2'd0,
      SEG_RX   = 2'd1,
      SEG_CMD  = 2'd2,
      SEG_NONE = 2'd3
   } seg_e;

   typedef enum logic [1:0] {
      CPU_IDLE = 2'd0,
      CPU_WAIT = 2'd1,
      CPU_ACK  = 2'd2
   } cpu_st_e;

   // Segment index (address divided by segment depth) to segment kind.
   function automatic seg_e seg_decode(input int unsigned idx);
      case (idx)
         0:       return SEG_TX;
         1:       return SEG_RX;
         2:       return SEG_CMD;
         default: return SEG_NONE;
      endcase
   endfunction

endpackage

// File: rtl/qram_addr_reg.sv
module qram_addr_reg #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              inc,
   output logic [ADDR_W-1:0] addr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr <= '0;
      else if (load) addr <= load_val;
      else if (inc)  addr <= addr + 1'b1;   // natural wrap at the top
   end

   // R5: each data access moves the pointer by exactly one, modulo the range
   a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load) |=> addr == ADDR_W'($past(addr) + 1'b1));

   // R2: a load takes the written value
   a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> addr == $past(load_val));

endmodule

// File: rtl/qram_store.sv
module qram_store
   import qram_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int SEG_DEPTH = 16,
   parameter int DATA_W    = 16,
   parameter int CMD_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              we,
   input  logic              ok,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int SEG_W  = $clog2(SEG_DEPTH);
   localparam int N_SEG  = 3;
   localparam int MAPPED = N_SEG * SEG_DEPTH;

   generate
      if ((1 << SEG_W) != SEG_DEPTH) begin : g_bad_depth
         $error("SEG_DEPTH must be a power of two");
      end
      if (MAPPED > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too narrow for three segments");
      end
      if (CMD_W > DATA_W) begin : g_bad_cmd
         $error("CMD_W must not exceed DATA_W");
      end
   endgenerate

   logic [SEG_W-1:0]  off;
   int unsigned       idx;
   logic [DATA_W-1:0] seg_rd [N_SEG];

   assign off = addr[SEG_W-1:0];
   assign idx = int'(addr >> SEG_W);

   for (genvar g = 0; g < N_SEG; g++) begin : g_seg
      localparam int W = (g == int'(SEG_CMD)) ? CMD_W : DATA_W;
      logic [W-1:0] mem [SEG_DEPTH];

      always_ff @(posedge clk) begin
         if (en && we && ok && idx == g) mem[off] <= wdata[W-1:0];
      end

      assign seg_rd[g] = DATA_W'(mem[off]);
   end

   logic [DATA_W-1:0] rd_sel;
   always_comb begin
      rd_sel = '0;
      for (int s = 0; s < N_SEG; s++) begin
         if (idx == s) rd_sel = seg_rd[s];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rdata <= '0;
      else if (en && !we) rdata <= ok ? rd_sel : '0;
   end

   // R1: reads beyond the three segments always give zero
   a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !we && int'(addr) >= MAPPED) |=> rdata == '0);

endmodule

// File: rtl/qram_cpu_fsm.sv
module qram_cpu_fsm
   import qram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_sel,
   input  logic              cpu_we,
   input  logic              seq_busy,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              go,
   output logic              addr_load,
   output logic              ack,
   output logic [DATA_W-1:0] rdata
);

   generate
      if (ADDR_W > DATA_W) begin : g_bad_w
         $error("pointer wider than data path");
      end
   endgenerate

   cpu_st_e st;

   assign go        = (st == CPU_IDLE) && cpu_req && cpu_sel && !seq_busy;
   assign addr_load = (st == CPU_IDLE) && cpu_req && !cpu_sel && cpu_we;
   assign ack       = (st == CPU_ACK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= CPU_IDLE;
         rdata <= '0;
      end else begin
         case (st)
            CPU_IDLE: begin
               if (cpu_req && !cpu_sel) begin
                  st <= CPU_ACK;
                  if (!cpu_we) rdata <= DATA_W'(addr);
               end else if (go) begin
                  st <= cpu_we ? CPU_ACK : CPU_WAIT;
               end
            end
            CPU_WAIT: begin
               rdata <= mem_rdata;   // the wait state
               st    <= CPU_ACK;
            end
            default: st <= CPU_IDLE;
         endcase
      end
   end

   // R6: a data read completes only after one wait cycle
   a_r6_read_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !cpu_we) |=> !ack ##1 ack);

   // R2: completion is a single-cycle pulse
   a_r2_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   // R10: a blocked data access cannot complete in the next cycle
   a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CPU_IDLE && cpu_req && cpu_sel && seq_busy) |=> !ack);

endmodule

// File: rtl/qram_port.sv
module qram_port
   import qram_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int SEG_DEPTH = 16,
   parameter int DATA_W    = 16,
   parameter int CMD_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_sel,
   input  logic              cpu_we,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ack,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              seq_req,
   input  logic              seq_we,
   input  logic [ADDR_W-1:0] seq_addr,
   input  logic [DATA_W-1:0] seq_wdata,
   output logic [DATA_W-1:0] seq_rdata
);

   localparam int SEG_W = $clog2(SEG_DEPTH);

   logic [ADDR_W-1:0] ptr;
   logic              cpu_go, ptr_load;
   logic              mem_en, mem_we, mem_ok;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_wdata, mem_rdata;
   seg_e              seg;

   // Sequencer has the RAM whenever it asks
   assign mem_en    = seq_req || cpu_go;
   assign mem_we    = seq_req ? seq_we    : cpu_we;
   assign mem_addr  = seq_req ? seq_addr  : ptr;
   assign mem_wdata = seq_req ? seq_wdata : cpu_wdata;
   assign seg       = seg_decode(int'(mem_addr >> SEG_W));

   always_comb begin
      if (seq_req)
         mem_ok = mem_we ? (seg == SEG_RX) : (seg == SEG_TX || seg == SEG_CMD);
      else
         mem_ok = mem_we ? (seg == SEG_TX || seg == SEG_CMD) : (seg == SEG_RX);
   end

   qram_addr_reg #(.ADDR_W(ADDR_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_load),
      .load_val (cpu_wdata[ADDR_W-1:0]),
      .inc      (cpu_go),
      .addr     (ptr)
   );

   qram_cpu_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_req   (cpu_req),
      .cpu_sel   (cpu_sel),
      .cpu_we    (cpu_we),
      .seq_busy  (seq_req),
      .addr      (ptr),
      .mem_rdata (mem_rdata),
      .go        (cpu_go),
      .addr_load (ptr_load),
      .ack       (cpu_ack),
      .rdata     (cpu_rdata)
   );

   qram_store #(
      .ADDR_W(ADDR_W), .SEG_DEPTH(SEG_DEPTH), .DATA_W(DATA_W), .CMD_W(CMD_W)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (mem_en),
      .we    (mem_we),
      .ok    (mem_ok),
      .addr  (mem_addr),
      .wdata (mem_wdata),
      .rdata (mem_rdata)
   );

   assign seq_rdata = mem_rdata;

   // R10: while the sequencer holds the RAM, a processor data access leaves the pointer alone
   a_r10_seq_first: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_req && cpu_sel) |=> $stable(ptr));

endmodule

// File: tb/qram_port_tb.sv
module qram_port_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_sel = 1'b0, cpu_we = 1'b0;
   logic [15:0] cpu_wdata = '0;
   logic        cpu_ack;
   logic [15:0] cpu_rdata;
   logic        seq_req = 1'b0, seq_we = 1'b0;
   logic [5:0]  seq_addr = '0;
   logic [15:0] seq_wdata = '0;
   logic [15:0] seq_rdata;

   int checks = 0;
   int errors = 0;
   logic [15:0] ov_rd;

   always #10 clk = ~clk;   // 50 MHz

   qram_port u_dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
      .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
      .seq_req(seq_req), .seq_we(seq_we), .seq_addr(seq_addr), .seq_wdata(seq_wdata),
      .seq_rdata(seq_rdata)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Processor access, optionally with a one-cycle sequencer access in the request cycle
   task automatic cpu_ov(input bit sel, input bit we, input logic [15:0] wd,
                         input bit so, input bit swe, input logic [5:0] sa,
                         input logic [15:0] swd,
                         output logic [15:0] rd, output int lat);
      @(negedge clk);
      cpu_req = 1'b1; cpu_sel = sel; cpu_we = we; cpu_wdata = wd;
      if (so) begin
         seq_req = 1'b1; seq_we = swe; seq_addr = sa; seq_wdata = swd;
      end
      lat = 0;
      do begin
         @(negedge clk);
         seq_req = 1'b0;
         lat++;
         if (lat == 1) ov_rd = seq_rdata;
      end while (!cpu_ack && lat < 10);
      rd = cpu_rdata;
      cpu_req = 1'b0;
   endtask

   task automatic cpu(input bit sel, input bit we, input logic [15:0] wd,
                      output logic [15:0] rd, output int lat);
      cpu_ov(sel, we, wd, 1'b0, 1'b0, '0, '0, rd, lat);
   endtask

   task automatic set_ptr(input logic [5:0] a);
      logic [15:0] d; int l;
      cpu(1'b0, 1'b1, 16'(a), d, l);
   endtask

   task automatic get_ptr(output logic [15:0] a);
      int l;
      cpu(1'b0, 1'b0, '0, a, l);
   endtask

   task automatic seq(input bit we, input logic [5:0] a, input logic [15:0] wd,
                      output logic [15:0] rd);
      @(negedge clk);
      seq_req = 1'b1; seq_we = we; seq_addr = a; seq_wdata = wd;
      @(negedge clk);
      rd = seq_rdata;
      seq_req = 1'b0;
   endtask

   task automatic t_reset();
      logic [15:0] p;
      chk("R11 ack", 16'(cpu_ack), 16'h0);
      chk("R11 cpu_rdata", cpu_rdata, 16'h0);
      chk("R11 seq_rdata", seq_rdata, 16'h0);
      get_ptr(p);
      chk("R11 pointer", p, 16'h0);
   endtask

   task automatic t_ptr_reg();
      logic [15:0] d; int l;
      cpu(1'b0, 1'b1, 16'hFFEA, d, l);
      chk("R2 write latency", 16'(l), 16'd1);
      cpu(1'b0, 1'b0, '0, d, l);
      chk("R2 read value", d, 16'h002A);
      chk("R2 read latency", 16'(l), 16'd1);
   endtask

   task automatic t_tx();
      logic [15:0] d, p; int l;
      set_ptr(6'h00);
      for (int i = 0; i < 4; i++) begin
         cpu(1'b1, 1'b1, 16'hA000 + 16'(i * 16'h0111), d, l);
         if (i == 0) chk("R3 write latency", 16'(l), 16'd1);
      end
      get_ptr(p);
      chk("R5 after four writes", p, 16'h0004);
      for (int i = 0; i < 4; i++) begin
         seq(1'b0, 6'(i), '0, d);
         chk("R3/R8 tx readback", d, 16'hA000 + 16'(i * 16'h0111));
      end
   endtask

   task automatic t_cmd();
      logic [15:0] d; int l;
      set_ptr(6'h20);
      cpu(1'b1, 1'b1, 16'hABCD, d, l);
      set_ptr(6'h2F);
      cpu(1'b1, 1'b1, 16'h7F5A, d, l);
      seq(1'b0, 6'h20, '0, d);
      chk("R1 cmd byte zero-extended", d, 16'h00CD);
      seq(1'b0, 6'h2F, '0, d);
      chk("R1 cmd last entry", d, 16'h005A);
   endtask

   task automatic t_rx();
      logic [15:0] d, p; int l;
      for (int i = 0; i < 4; i++) seq(1'b1, 6'h10 + 6'(i), 16'h5100 + 16'(i), d);
      set_ptr(6'h10);
      for (int i = 0; i < 4; i++) begin
         cpu(1'b1, 1'b0, '0, d, l);
         chk("R6/R9 rx read", d, 16'h5100 + 16'(i));
         chk("R6 read latency", 16'(l), 16'd2);
      end
      get_ptr(p);
      chk("R5 after reads", p, 16'h0014);
   endtask

   task automatic t_forbid();
      logic [15:0] d, p; int l;
      set_ptr(6'h12);
      cpu(1'b1, 1'b1, 16'hDEAD, d, l);
      get_ptr(p);
      chk("R5 discarded write increments", p, 16'h0013);
      set_ptr(6'h12);
      cpu(1'b1, 1'b0, '0, d, l);
      chk("R4 rx unchanged by cpu write", d, 16'h5102);
      set_ptr(6'h01);
      cpu(1'b1, 1'b0, '0, d, l);
      chk("R7 tx read zero", d, 16'h0);
      get_ptr(p);
      chk("R5 discarded read increments", p, 16'h0002);
      set_ptr(6'h20);
      cpu(1'b1, 1'b0, '0, d, l);
      chk("R7 cmd read zero", d, 16'h0);
   endtask

   task automatic t_unmapped();
      logic [15:0] d; int l;
      set_ptr(6'h30);
      cpu(1'b1, 1'b1, 16'h1234, d, l);
      set_ptr(6'h30);
      cpu(1'b1, 1'b0, '0, d, l);
      chk("R7 unmapped cpu read", d, 16'h0);
      seq(1'b0, 6'h30, '0, d);
      chk("R1 unmapped seq read", d, 16'h0);
      seq(1'b1, 6'h35, 16'hBEEF, d);
      seq(1'b0, 6'h35, '0, d);
      chk("R1 unmapped seq write dropped", d, 16'h0);
   endtask

   task automatic t_wrap();
      logic [15:0] d, p; int l;
      set_ptr(6'h3F);
      cpu(1'b1, 1'b1, 16'h4444, d, l);
      get_ptr(p);
      chk("R5 wrap to zero", p, 16'h0000);
   endtask

   task automatic t_seq_rules();
      logic [15:0] d;
      seq(1'b1, 6'h01, 16'h9999, d);
      seq(1'b0, 6'h01, '0, d);
      chk("R9 seq write to tx dropped", d, 16'hA111);
      seq(1'b0, 6'h11, '0, d);
      chk("R8 seq read of rx zero", d, 16'h0);
   endtask

   task automatic t_collide();
      logic [15:0] d, p; int l;
      set_ptr(6'h05);
      cpu_ov(1'b1, 1'b1, 16'h0C0C, 1'b1, 1'b0, 6'h02, '0, d, l);
      chk("R10 stalled write latency", 16'(l), 16'd2);
      chk("R10 seq read served first", ov_rd, 16'hA222);
      seq(1'b0, 6'h05, '0, d);
      chk("R10 stalled write landed", d, 16'h0C0C);
      set_ptr(6'h13);
      cpu_ov(1'b1, 1'b0, '0, 1'b1, 1'b0, 6'h20, '0, d, l);
      chk("R10 stalled read latency", 16'(l), 16'd3);
      chk("R10 stalled read data", d, 16'h5103);
      cpu_ov(1'b0, 1'b0, '0, 1'b1, 1'b0, 6'h00, '0, p, l);
      chk("R10 pointer access not delayed", 16'(l), 16'd1);
      chk("R10 pointer after stalled read", p, 16'h0014);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ptr_reg();
      t_tx();
      t_cmd();
      t_rx();
      t_forbid();
      t_unmapped();
      t_wrap();
      t_seq_rules();
      t_collide();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule